// File: doc/BRIEF.md
# Three-Phase Gate-Enable Protection Supervisor

This block sits between the six PWM gate commands of a three-phase bridge (one high-side and one low-side command per phase) and the six gate-enable lines that feed the drive stages. It qualifies every command against a minimum pulse width. It then passes qualified commands through to the gate enables unless a protection condition holds the channel off. The comparators that sense supply levels and shunt current are outside the block. It receives their results as clean, already-debounced logic flags.

Each fault class has its own reach. A short-circuit trip or a low-side supply undervoltage turns off all three low-side enables and pulls an active-low fault line down for a fixed number of cycles. A high-side bias undervoltage disables only the high-side enable of its own phase and never touches the fault line. Undervoltage is held in a latch with separate detect and release flag inputs, which gives the block hysteresis. A disabled channel does not resume on a command that is still high. It waits for the next qualified low-to-high command transition. As a further safeguard, when both commands of one phase are high together, both enables of that phase are forced off.

Top module: `phase_gate_supervisor`

## Requirements
- R1: After reset, every gate enable is 0, fault_n is 1, and every channel is disarmed.
- R2: A command change takes effect only after the raw input has held its new value for MIN_W consecutive clock cycles. A pulse of MIN_W-1 cycles or fewer never reaches a gate enable.
- R3: With no fault present, a command that rises and stays high sets its gate enable to 1 in the (MIN_W+1)-th cycle after the first cycle in which it is sampled high. A command that falls clears the enable with the same latency.
- R4: A cycle with sc_trip high clears all three low-side enables in the next cycle. The high-side enables are unaffected.
- R5: A cycle with sc_trip or lv_uv_set high drives fault_n to 0 from the next cycle on, for exactly FO_W cycles, and then fault_n returns to 1.
- R6: A new trigger of the kind in R5 that arrives while fault_n is low restarts the FO_W count from the beginning.
- R7: lv_uv_set latches a low-side undervoltage state, and lv_uv_clr releases it. When both are high in the same cycle, set wins. While the state is latched, all low-side enables stay 0, including after the fault pulse has ended.
- R8: hs_uv_set[i] latches an undervoltage state for phase i, and hs_uv_clr[i] releases it. While the state is latched, gate_hi[i] stays 0. The other phases and fault_n are unaffected.
- R9: After an undervoltage release or the end of a fault pulse, a channel whose command is still high stays off. It turns on only after a fresh qualified low-to-high transition of its command.
- R10: While fault_n is 0, no low-side enable turns on, even when a low-side command rises during the pulse.
- R11: When both qualified commands of one phase are high, both enables of that phase are 0. When one command drops, the other channel resumes without needing a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hi | input | NPH | High-side PWM commands, active high, bit i = phase i |
| cmd_lo | input | NPH | Low-side PWM commands, active high, bit i = phase i |
| lv_uv_set | input | 1 | Low-side supply below its detect level |
| lv_uv_clr | input | 1 | Low-side supply above its release level |
| hs_uv_set | input | NPH | Per-phase high-side bias below its detect level |
| hs_uv_clr | input | NPH | Per-phase high-side bias above its release level |
| sc_trip | input | 1 | Low-side short-circuit current trip |
| gate_hi | output | NPH | High-side gate enables |
| gate_lo | output | NPH | Low-side gate enables |
| fault_n | output | 1 | Fault line, active low, pulsed for FO_W cycles |

## Verification
The bench drives steady commands and also drives a glitch one cycle shorter than the qualifier window. Together these separate a correct width filter from a plain pass-through, and the exact-cycle samples expose any added or missing pipeline stage. Fault sequences combine a short-circuit pulse, a back-to-back retrigger and an undervoltage that outlasts the fault pulse. Each sequence holds the commands high across the release, which separates edge re-arming from level following and separates latched undervoltage from pulse-limited blocking. Single-phase high-side undervoltage and overlapping commands on one phase confirm that each condition reaches only the channels it should.

// File: rtl/gsup_pkg.sv
package gsup_pkg;
    localparam int unsigned GSUP_NPH   = 3;
    localparam int unsigned GSUP_MIN_W = 4;
    localparam int unsigned GSUP_FO_W  = 50;

    // Per-channel arming state
    typedef struct packed {
        logic prev;   // qualified command seen last cycle
        logic armed;  // channel may drive its gate
        logic gate;   // registered gate enable
    } chan_st_t;
endpackage

// File: rtl/gsup_cmd_qual.sv
module gsup_cmd_qual #(
    parameter int unsigned MIN_W = gsup_pkg::GSUP_MIN_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic qual
);
    localparam int unsigned CW = (MIN_W < 2) ? 1 : $clog2(MIN_W);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } qst_t;

    qst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (int'(st_q.cnt) + 1 >= int'(MIN_W)) begin
            st_d.lvl = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual = st_q.lvl;
endmodule

// File: rtl/gsup_fault_timer.sv
module gsup_fault_timer #(
    parameter int unsigned FO_W = gsup_pkg::GSUP_FO_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int unsigned CW = $clog2(FO_W + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tst_t;

    tst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig)                 st_d.cnt = CW'(FO_W);
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);
endmodule

// File: rtl/gsup_chan.sv
module gsup_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic kill,
    input  logic shoot,
    output logic gate
);
    import gsup_pkg::*;

    chan_st_t st_d, st_q;
    logic     rise;

    always_comb begin
        st_d       = st_q;
        rise       = cmd & ~st_q.prev;
        st_d.prev  = cmd;
        st_d.armed = kill ? 1'b0 : (st_q.armed | rise);
        st_d.gate  = st_d.armed & cmd & ~shoot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate = st_q.gate;
endmodule

// File: rtl/phase_gate_supervisor.sv
module phase_gate_supervisor #(
    parameter int unsigned NPH   = gsup_pkg::GSUP_NPH,
    parameter int unsigned MIN_W = gsup_pkg::GSUP_MIN_W,
    parameter int unsigned FO_W  = gsup_pkg::GSUP_FO_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] cmd_hi,
    input  logic [NPH-1:0] cmd_lo,
    input  logic           lv_uv_set,
    input  logic           lv_uv_clr,
    input  logic [NPH-1:0] hs_uv_set,
    input  logic [NPH-1:0] hs_uv_clr,
    input  logic           sc_trip,
    output logic [NPH-1:0] gate_hi,
    output logic [NPH-1:0] gate_lo,
    output logic           fault_n
);
    typedef struct packed {
        logic           lv_uv;
        logic [NPH-1:0] hs_uv;
    } uv_st_t;

    uv_st_t uv_d, uv_q;

    logic [NPH-1:0] qh, ql;
    logic [NPH-1:0] kill_hi, shoot;
    logic           kill_lo, flt_act, flt_trig;

    // Undervoltage latches: detect sets, release clears, set has priority
    always_comb begin
        uv_d       = uv_q;
        uv_d.lv_uv = lv_uv_set | (uv_q.lv_uv & ~lv_uv_clr);
        uv_d.hs_uv = hs_uv_set | (uv_q.hs_uv & ~hs_uv_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uv_q <= '0;
        else        uv_q <= uv_d;
    end

    assign flt_trig = sc_trip | lv_uv_set;

    gsup_fault_timer #(.FO_W(FO_W)) u_ftmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (flt_trig),
        .active (flt_act)
    );

    assign kill_lo = uv_q.lv_uv | lv_uv_set | sc_trip | flt_act;
    assign kill_hi = uv_q.hs_uv | hs_uv_set;
    assign shoot   = qh & ql;

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        gsup_cmd_qual #(.MIN_W(MIN_W)) u_qh (
            .clk (clk), .rst_n (rst_n), .raw (cmd_hi[p]), .qual (qh[p])
        );
        gsup_cmd_qual #(.MIN_W(MIN_W)) u_ql (
            .clk (clk), .rst_n (rst_n), .raw (cmd_lo[p]), .qual (ql[p])
        );
        gsup_chan u_ch_hi (
            .clk (clk), .rst_n (rst_n), .cmd (qh[p]),
            .kill (kill_hi[p]), .shoot (shoot[p]), .gate (gate_hi[p])
        );
        gsup_chan u_ch_lo (
            .clk (clk), .rst_n (rst_n), .cmd (ql[p]),
            .kill (kill_lo), .shoot (shoot[p]), .gate (gate_lo[p])
        );
    end

    assign fault_n = ~flt_act;
endmodule

// File: rtl/gsup_checker.sv
module gsup_checker #(
    parameter int unsigned NPH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sc_trip,
    input logic           lv_uv_set,
    input logic [NPH-1:0] hs_uv_set,
    input logic [NPH-1:0] gate_hi,
    input logic [NPH-1:0] gate_lo,
    input logic           fault_n
);
    // R4
    sc_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_trip |=> (gate_lo == '0));

    // R5
    sc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_trip || lv_uv_set) |=> !fault_n);

    // R7
    lvuv_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lv_uv_set |=> (gate_lo == '0));

    // R10
    fault_lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_lo == '0));

    // R11
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R8
    hs_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n && !sc_trip && !lv_uv_set) |=> fault_n);

    for (genvar p = 0; p < NPH; p++) begin : g_hs
        // R8
        hsuv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hs_uv_set[p] |=> !gate_hi[p]);
    end
endmodule

bind phase_gate_supervisor gsup_checker #(.NPH(NPH)) u_gsup_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sc_trip   (sc_trip),
    .lv_uv_set (lv_uv_set),
    .hs_uv_set (hs_uv_set),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .fault_n   (fault_n)
);

// File: tb/tb_phase_gate_supervisor.sv
module tb_phase_gate_supervisor;
    localparam int CLK_P = 10;
    localparam int NPH   = 3;
    localparam int MIN_W = 4;
    localparam int FO_W  = 50;
    localparam int SETL  = MIN_W + 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NPH-1:0] cmd_hi, cmd_lo, hs_uv_set, hs_uv_clr;
    logic           lv_uv_set, lv_uv_clr, sc_trip;
    logic [NPH-1:0] gate_hi, gate_lo;
    logic           fault_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    phase_gate_supervisor #(.NPH(NPH), .MIN_W(MIN_W), .FO_W(FO_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .lv_uv_set(lv_uv_set), .lv_uv_clr(lv_uv_clr),
        .hs_uv_set(hs_uv_set), .hs_uv_clr(hs_uv_clr), .sc_trip(sc_trip),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ck(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic pulse_sc();
        sc_trip = 1'b1; tick(1); sc_trip = 1'b0;
    endtask

    task automatic t_reset();
        ck("R1 gate_hi", int'(gate_hi), 0);
        ck("R1 gate_lo", int'(gate_lo), 0);
        ck("R1 fault_n", int'(fault_n), 1);
    endtask

    task automatic t_pass();
        cmd_lo[0] = 1'b1;
        tick(MIN_W);
        ck("R2 no early gate_lo0", int'(gate_lo[0]), 0);
        tick(1);
        ck("R3 gate_lo0 on", int'(gate_lo[0]), 1);
        cmd_lo[0] = 1'b0;
        tick(MIN_W);
        ck("R3 gate_lo0 held", int'(gate_lo[0]), 1);
        tick(1);
        ck("R3 gate_lo0 off", int'(gate_lo[0]), 0);
        cmd_hi[1] = 1'b1;
        tick(MIN_W + 1);
        ck("R3 gate_hi1 on", int'(gate_hi[1]), 1);
        cmd_hi[1] = 1'b0;
        tick(SETL);
    endtask

    task automatic t_glitch();
        cmd_lo[1] = 1'b1;
        tick(MIN_W - 1);
        cmd_lo[1] = 1'b0;
        tick(8);
        ck("R2 short pulse ignored", int'(gate_lo[1]), 0);
    endtask

    task automatic t_sc();
        int used;
        cmd_lo = 3'b110; cmd_hi = 3'b001;
        tick(SETL);
        ck("R3 lo pattern", int'(gate_lo), 6);
        pulse_sc();
        ck("R4 lo off", int'(gate_lo), 0);
        ck("R4 hi kept", int'(gate_hi), 1);
        ck("R5 fault low", int'(fault_n), 0);
        tick(5);
        cmd_lo[1] = 1'b0;
        tick(SETL);
        cmd_lo[1] = 1'b1;
        tick(SETL);
        ck("R10 rise during fault", int'(gate_lo[1]), 0);
        used = 5 + 2 * SETL;
        tick(FO_W - 1 - used);
        ck("R5 fault still low", int'(fault_n), 0);
        tick(1);
        ck("R5 fault ended", int'(fault_n), 1);
        tick(3);
        ck("R9 no level restart", int'(gate_lo), 0);
        cmd_lo[2] = 1'b0;
        tick(SETL);
        cmd_lo[2] = 1'b1;
        tick(SETL);
        ck("R9 fresh edge restart", int'(gate_lo), 4);
        cmd_lo = '0; cmd_hi = '0;
        tick(SETL);
    endtask

    task automatic t_retrig();
        pulse_sc();
        tick(20);
        lv_uv_set = 1'b1; lv_uv_clr = 1'b1; tick(1);
        lv_uv_set = 1'b0;
        tick(1);
        lv_uv_clr = 1'b0;
        pulse_sc();
        ck("R6 fault low", int'(fault_n), 0);
        tick(FO_W - 1);
        ck("R6 restarted", int'(fault_n), 0);
        tick(1);
        ck("R6 end", int'(fault_n), 1);
        tick(2);
    endtask

    task automatic t_lvuv();
        cmd_lo[0] = 1'b1;
        tick(SETL);
        ck("R3 lo0 on", int'(gate_lo[0]), 1);
        lv_uv_set = 1'b1; lv_uv_clr = 1'b1;
        tick(1);
        lv_uv_set = 1'b0; lv_uv_clr = 1'b0;
        ck("R7 lo off", int'(gate_lo), 0);
        ck("R7 fault low", int'(fault_n), 0);
        tick(FO_W + 2);
        ck("R7 fault ended", int'(fault_n), 1);
        cmd_lo[0] = 1'b0; tick(SETL);
        cmd_lo[0] = 1'b1; tick(SETL);
        ck("R7 held off past pulse", int'(gate_lo[0]), 0);
        lv_uv_clr = 1'b1; tick(1); lv_uv_clr = 1'b0;
        tick(3);
        ck("R9 lo0 waits edge", int'(gate_lo[0]), 0);
        cmd_lo[0] = 1'b0; tick(SETL);
        cmd_lo[0] = 1'b1; tick(SETL);
        ck("R9 lo0 restarts", int'(gate_lo[0]), 1);
        cmd_lo = '0; tick(SETL);
    endtask

    task automatic t_hsuv();
        cmd_hi = 3'b111;
        tick(SETL);
        ck("R3 hi all", int'(gate_hi), 7);
        hs_uv_set[1] = 1'b1; tick(1); hs_uv_set[1] = 1'b0;
        ck("R8 hi1 off", int'(gate_hi), 5);
        ck("R8 no fault", int'(fault_n), 1);
        tick(5);
        ck("R8 still no fault", int'(fault_n), 1);
        hs_uv_clr[1] = 1'b1; tick(1); hs_uv_clr[1] = 1'b0;
        tick(3);
        ck("R9 hi1 waits edge", int'(gate_hi), 5);
        cmd_hi[1] = 1'b0; tick(SETL);
        cmd_hi[1] = 1'b1; tick(SETL);
        ck("R9 hi1 restarts", int'(gate_hi), 7);
        cmd_hi = '0; tick(SETL);
    endtask

    task automatic t_shoot();
        cmd_hi[2] = 1'b1; tick(SETL);
        ck("R3 hi2 on", int'(gate_hi[2]), 1);
        cmd_lo[2] = 1'b1; tick(SETL);
        ck("R11 hi2 off", int'(gate_hi[2]), 0);
        ck("R11 lo2 off", int'(gate_lo[2]), 0);
        cmd_lo[2] = 1'b0; tick(SETL);
        ck("R11 hi2 resumes", int'(gate_hi[2]), 1);
        cmd_hi = '0; tick(SETL);
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cmd_hi = '0; cmd_lo = '0; hs_uv_set = '0; hs_uv_clr = '0;
        lv_uv_set = 1'b0; lv_uv_clr = 1'b0; sc_trip = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_pass();
        t_glitch();
        t_sc();
        t_retrig();
        t_lvuv();
        t_hsuv();
        t_shoot();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule